// File: doc/BRIEF.md
# Paged 32-bit Register Bridge

This block lets a requester read and write 32-bit registers in a switch that is reached only through a 16-bit management bus with a page window. Each accepted request is turned into an ordered sequence of sub-transactions. First the page number is written into a page-select register. Then the block waits a programmable number of clock cycles for the page change to take effect. Finally it moves the two 16-bit halves of the data word.

The register address is cut into fixed fields. The fields select the page, the device address on the management bus and the register number within that device. A read assembles the two halves into one 32-bit word. A write splits the word into two halves and sends them in a fixed order. Only one request is in flight at a time. The sub-transaction side is an abstract port that carries device address, register number, write data and read data under a valid/done handshake. The serial pin timing sits outside this block.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, reqReady is 1, mgmtValid is 0 and rspValid is 0.
- R2: The register address is split as follows: page = reqAddr[17:9]; device = 0x10 OR reqAddr[8:6]; low register = {reqAddr[5:2], 0}; high register = low register + 1. reqAddr[1:0] has no effect on any sub-transaction.
- R3: The first sub-transaction of every request writes the page, zero-extended to 16 bits, to device 0x18, register 0.
- R4: After the page write completes, mgmtValid stays low for exactly SETTLE_CYCLES clock cycles before the first data sub-transaction.
- R5: A read fetches the low half from the low register, then the high half from the high register, and returns rspRdata = {high, low}.
- R6: A write sends reqWdata[31:16] to the high register first, then reqWdata[15:0] to the low register.
- R7: mgmtValid and the sub-transaction fields stay unchanged until mgmtDone, and read data is taken from mgmtRdata in the cycle mgmtDone is high.
- R8: reqReady is low from the cycle after acceptance until the response. A reqValid raised while reqReady is low starts no sub-transaction.
- R9: rspValid is high for exactly one cycle, in the cycle after the last mgmtDone, and reqReady is high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Bridge idle, request accepted when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | 32-bit register address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Assembled read data |
| mgmtValid | output | 1 | Sub-transaction request |
| mgmtWrite | output | 1 | Sub-transaction is a write |
| mgmtDev | output | 5 | Management device address |
| mgmtReg | output | 5 | Management register number |
| mgmtWdata | output | 16 | Sub-transaction write data |
| mgmtRdata | input | 16 | Sub-transaction read data |
| mgmtDone | input | 1 | Sub-transaction complete |

## Verification
The assertions assume that the management side raises mgmtDone only while mgmtValid is high, and for a single cycle per sub-transaction. They also assume that SETTLE_CYCLES is at least one. The bench responder follows this: it waits a configurable latency after seeing mgmtValid, pulses mgmtDone once, and then lowers it before it looks at the next request. Requests are raised only while reqReady is high, except in the dedicated case that probes whether requests are ignored while the bridge is busy.

// File: rtl/paged_reg_bridge_pkg.sv
package paged_reg_bridge_pkg;

  localparam int MDEV_W  = 5;
  localparam int MREG_W  = 5;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_SETTLE,
    ST_FIRST,
    ST_SECOND,
    ST_RESP
  } bridgeState_t;

  typedef enum logic [1:0] {
    PH_PAGE,
    PH_FIRST,
    PH_SECOND
  } phase_t;

  typedef struct packed {
    logic   latchReq;
    logic   capFirst;
    logic   capSecond;
    phase_t phase;
  } dpStrobe_t;

endpackage

// File: rtl/paged_reg_bridge_dpath.sv
module paged_reg_bridge_dpath
  import paged_reg_bridge_pkg::*;
#(
  parameter int PAGE_W   = 9,
  parameter int DEVSEL_W = 3,
  parameter int REGSEL_W = 4,
  parameter logic [MDEV_W-1:0] DEV_BASE = 5'h10,
  parameter logic [MDEV_W-1:0] PAGE_DEV = 5'h18,
  parameter logic [MREG_W-1:0] PAGE_REG = 5'h00,
  localparam int ADDR_W = 2 + REGSEL_W + DEVSEL_W + PAGE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqWdata,
  input  logic [HALF_W-1:0]   mgmtRdata,
  output logic                mgmtWrite,
  output logic [MDEV_W-1:0]   mgmtDev,
  output logic [MREG_W-1:0]   mgmtReg,
  output logic [HALF_W-1:0]   mgmtWdata,
  output logic [WORD_W-1:0]   rspRdata
);

  localparam int REG_LSB = 2;
  localparam int DEV_LSB = REG_LSB + REGSEL_W;
  localparam int PAG_LSB = DEV_LSB + DEVSEL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wdataQ;
  logic              writeQ;
  logic [WORD_W-1:0] rdataQ;

  logic [PAGE_W-1:0]   pageSel;
  logic [DEVSEL_W-1:0] devSel;
  logic [REGSEL_W-1:0] regSel;
  logic [MDEV_W-1:0]   dataDev;
  logic [MREG_W-1:0]   lowReg;
  logic [MREG_W-1:0]   highReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else begin
      if (strobe.capFirst && !writeQ)  rdataQ[HALF_W-1:0]      <= mgmtRdata;
      if (strobe.capSecond && !writeQ) rdataQ[WORD_W-1:HALF_W] <= mgmtRdata;
    end
  end

  assign pageSel = addrQ[PAG_LSB +: PAGE_W];
  assign devSel  = addrQ[DEV_LSB +: DEVSEL_W];
  assign regSel  = addrQ[REG_LSB +: REGSEL_W];

  assign dataDev = DEV_BASE | MDEV_W'(devSel);
  assign lowReg  = MREG_W'({regSel, 1'b0});
  assign highReg = MREG_W'({regSel, 1'b1});

  always_comb begin
    mgmtWrite = 1'b1;
    mgmtDev   = PAGE_DEV;
    mgmtReg   = PAGE_REG;
    mgmtWdata = HALF_W'(pageSel);
    unique case (strobe.phase)
      PH_FIRST: begin
        mgmtWrite = writeQ;
        mgmtDev   = dataDev;
        mgmtReg   = writeQ ? highReg : lowReg;
        mgmtWdata = writeQ ? wdataQ[WORD_W-1:HALF_W] : '0;
      end
      PH_SECOND: begin
        mgmtWrite = writeQ;
        mgmtDev   = dataDev;
        mgmtReg   = writeQ ? lowReg : highReg;
        mgmtWdata = writeQ ? wdataQ[HALF_W-1:0] : '0;
      end
      default: ;
    endcase
  end

  assign rspRdata = rdataQ;

endmodule

// File: rtl/paged_reg_bridge_ctrl.sv
module paged_reg_bridge_ctrl
  import paged_reg_bridge_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      mgmtDone,
  output logic      reqReady,
  output logic      mgmtValid,
  output logic      rspValid,
  output dpStrobe_t strobe
);

  bridgeState_t state, stateNext;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid)   stateNext = ST_PAGE;
      ST_PAGE:   if (mgmtDone)   stateNext = ST_SETTLE;
      ST_SETTLE: if (settleCnt == '0) stateNext = ST_FIRST;
      ST_FIRST:  if (mgmtDone)   stateNext = ST_SECOND;
      ST_SECOND: if (mgmtDone)   stateNext = ST_RESP;
      ST_RESP:                   stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (state == ST_PAGE && mgmtDone) begin
      settleCnt <= CNT_W'(SETTLE_CYCLES - 1);
    end else if (state == ST_SETTLE && settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign rspValid  = (state == ST_RESP);
  assign mgmtValid = (state == ST_PAGE) || (state == ST_FIRST) || (state == ST_SECOND);

  always_comb begin
    strobe.latchReq  = (state == ST_IDLE) && reqValid;
    strobe.capFirst  = (state == ST_FIRST) && mgmtDone;
    strobe.capSecond = (state == ST_SECOND) && mgmtDone;
    unique case (state)
      ST_FIRST:  strobe.phase = PH_FIRST;
      ST_SECOND: strobe.phase = PH_SECOND;
      default:   strobe.phase = PH_PAGE;
    endcase
  end

endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import paged_reg_bridge_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int PAGE_W   = 9,
  parameter int DEVSEL_W = 3,
  parameter int REGSEL_W = 4,
  parameter logic [4:0] DEV_BASE = 5'h10,
  parameter logic [4:0] PAGE_DEV = 5'h18,
  localparam int ADDR_W = 2 + REGSEL_W + DEVSEL_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              mgmtValid,
  output logic              mgmtWrite,
  output logic [4:0]        mgmtDev,
  output logic [4:0]        mgmtReg,
  output logic [15:0]       mgmtWdata,
  input  logic [15:0]       mgmtRdata,
  input  logic              mgmtDone
);

  dpStrobe_t strobe;

  paged_reg_bridge_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .mgmtDone (mgmtDone),
    .reqReady (reqReady),
    .mgmtValid(mgmtValid),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  paged_reg_bridge_dpath #(
    .PAGE_W  (PAGE_W),
    .DEVSEL_W(DEVSEL_W),
    .REGSEL_W(REGSEL_W),
    .DEV_BASE(DEV_BASE),
    .PAGE_DEV(PAGE_DEV),
    .PAGE_REG(5'h00)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .mgmtRdata(mgmtRdata),
    .mgmtWrite(mgmtWrite),
    .mgmtDev  (mgmtDev),
    .mgmtReg  (mgmtReg),
    .mgmtWdata(mgmtWdata),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/paged_reg_bridge_chk.sv
module paged_reg_bridge_chk #(
  parameter logic [4:0] PAGE_DEV = 5'h18
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic        mgmtValid,
  input logic        mgmtWrite,
  input logic [4:0]  mgmtDev,
  input logic [4:0]  mgmtReg,
  input logic [15:0] mgmtWdata,
  input logic        mgmtDone
);

  // R3
  page_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (mgmtValid && mgmtWrite && mgmtDev == PAGE_DEV && mgmtReg == 5'h00));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtValid && !mgmtDone) |=> (mgmtValid && $stable(mgmtDev) && $stable(mgmtReg)
                                  && $stable(mgmtWrite) && $stable(mgmtWdata)));

  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtValid && mgmtDone && mgmtDev == PAGE_DEV) |=> !mgmtValid);

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (reqReady && !rspValid));

  // R2
  dev_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    mgmtValid |-> (mgmtDev[4] && !reqReady && !rspValid));

endmodule

bind paged_reg_bridge paged_reg_bridge_chk #(.PAGE_DEV(PAGE_DEV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .mgmtValid(mgmtValid),
  .mgmtWrite(mgmtWrite),
  .mgmtDev  (mgmtDev),
  .mgmtReg  (mgmtReg),
  .mgmtWdata(mgmtWdata),
  .mgmtDone (mgmtDone)
);

// File: tb/paged_reg_bridge_bench.sv
module paged_reg_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        mgmtValid;
  logic        mgmtWrite;
  logic [4:0]  mgmtDev;
  logic [4:0]  mgmtReg;
  logic [15:0] mgmtWdata;
  logic [15:0] mgmtRdata = 16'hdead;
  logic        mgmtDone = 1'b0;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  bit finished = 1'b0;

  logic [15:0] mem [0:1023];
  logic        logW    [0:255];
  logic [4:0]  logDev  [0:255];
  logic [4:0]  logReg  [0:255];
  logic [15:0] logData [0:255];
  int logN = 0;
  int lastGap = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_reg_bridge #(.SETTLE_CYCLES(SETTLE)) u_paged_reg_bridge (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .mgmtValid(mgmtValid), .mgmtWrite(mgmtWrite), .mgmtDev(mgmtDev),
    .mgmtReg(mgmtReg), .mgmtWdata(mgmtWdata),
    .mgmtRdata(mgmtRdata), .mgmtDone(mgmtDone)
  );

  // Management-side responder with logging and settle-gap measurement
  initial begin
    int waitCnt;
    bit measuring;
    waitCnt = 0;
    measuring = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 37) + 16'h1234);
    forever begin
      @(negedge clk);
      if (measuring) begin
        if (!mgmtValid) lastGap++;
        else measuring = 1'b0;
      end
      if (mgmtDone) begin
        mgmtDone  = 1'b0;
        mgmtRdata = 16'hdead;
      end else if (mgmtValid) begin
        if (waitCnt >= lat) begin
          waitCnt = 0;
          if (logN < 256) begin
            logW[logN] = mgmtWrite; logDev[logN] = mgmtDev;
            logReg[logN] = mgmtReg; logData[logN] = mgmtWrite ? mgmtWdata : mem[{mgmtDev, mgmtReg}];
          end
          logN++;
          if (mgmtWrite) mem[{mgmtDev, mgmtReg}] = mgmtWdata;
          else           mgmtRdata = mem[{mgmtDev, mgmtReg}];
          mgmtDone = 1'b1;
          if (mgmtWrite && mgmtDev == 5'h18) begin
            measuring = 1'b1;
            lastGap = 0;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] eDev(input logic [17:0] a);
    return 5'h10 | {2'b00, a[8:6]};
  endfunction
  function automatic logic [4:0] eLow(input logic [17:0] a);
    return {a[5:2], 1'b0};
  endfunction

  // Issue one request; optionally poke reqValid while busy
  task automatic runReq(input bit w, input logic [17:0] a, input logic [31:0] d,
                        input bit poke, output logic [31:0] rd, output int start);
    int guard;
    @(negedge clk);
    chk(reqReady == 1'b1, "R8 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    start = logN;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R8 busy after accept", 32'(reqReady), 32'd0);
    if (poke) begin
      reqValid = 1'b1; reqWrite = ~w; reqAddr = ~a; reqWdata = ~d;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(reqReady == 1'b0, "R8 busy while poked", 32'(reqReady), 32'd0);
      end
      reqValid = 1'b0;
    end
    guard = 0;
    while (!rspValid && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(rspValid == 1'b1, "R9 response seen", 32'(rspValid), 32'd1);
    rd = rspRdata;
    chk(logN - start == 3, "R8 three sub-transactions before response", 32'(logN - start), 32'd3);
    @(negedge clk);
    chk(rspValid == 1'b0, "R9 response one cycle", 32'(rspValid), 32'd0);
    chk(reqReady == 1'b1, "R9 ready after response", 32'(reqReady), 32'd1);
    chk(logN - start == 3, "R8 no extra sub-transactions", 32'(logN - start), 32'd3);
    chk(lastGap == SETTLE, "R4 settle gap", 32'(lastGap), 32'(SETTLE));
  endtask

  task automatic chkPage(input int s, input logic [17:0] a);
    chk(logW[s] == 1'b1 && logDev[s] == 5'h18 && logReg[s] == 5'h00,
        "R3 page target", {22'b0, logW[s], logDev[s], logReg[s]}, {22'b0, 1'b1, 5'h18, 5'h00});
    chk(logData[s] == {7'b0, a[17:9]}, "R3 page value", 32'(logData[s]), 32'({7'b0, a[17:9]}));
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", 32'(reqReady), 32'd1);
    chk(mgmtValid == 1'b0, "R1 mgmtValid", 32'(mgmtValid), 32'd0);
    chk(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 32'd0);
  endtask

  task automatic testRead(input logic [17:0] a, input int latency, input bit poke);
    logic [31:0] rd, exp;
    int s;
    lat = latency;
    exp = {mem[{eDev(a), eLow(a) | 5'd1}], mem[{eDev(a), eLow(a)}]};
    runReq(1'b0, a, 32'h0, poke, rd, s);
    chkPage(s, a);
    chk(logW[s+1] == 1'b0 && logDev[s+1] == eDev(a) && logReg[s+1] == eLow(a),
        "R2 R5 first read low register", {26'b0, logDev[s+1], logW[s+1]}, {26'b0, eDev(a), 1'b0});
    chk(logReg[s+2] == (eLow(a) | 5'd1) && logW[s+2] == 1'b0,
        "R5 second read high register", 32'(logReg[s+2]), 32'(eLow(a) | 5'd1));
    chk(rd == exp, "R5 R7 assembled read data", rd, exp);
  endtask

  task automatic testWrite(input logic [17:0] a, input logic [31:0] d, input int latency);
    logic [31:0] rd;
    int s;
    lat = latency;
    runReq(1'b1, a, d, 1'b0, rd, s);
    chkPage(s, a);
    chk(logW[s+1] && logDev[s+1] == eDev(a) && logReg[s+1] == (eLow(a) | 5'd1) && logData[s+1] == d[31:16],
        "R6 high half first", {logData[s+1], 11'b0, logReg[s+1]}, {d[31:16], 11'b0, eLow(a) | 5'd1});
    chk(logW[s+2] && logReg[s+2] == eLow(a) && logData[s+2] == d[15:0],
        "R6 low half second", {logData[s+2], 11'b0, logReg[s+2]}, {d[15:0], 11'b0, eLow(a)});
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead(18'h0A5C4, 1, 1'b0);
    testWrite(18'h13A68, 32'hCAFE_F00D, 3);
    testRead(18'h13A68, 0, 1'b0);
    testRead(18'h13A6B, 2, 1'b0);   // R2 low address bits ignored
    testWrite(18'h3FFFF, 32'h8001_7FFE, 2);
    testRead(18'h3FFFC, 1, 1'b0);
    testRead(18'h00000, 4, 1'b1);   // R8 request while busy
    testWrite(18'h00204, 32'h0102_0304, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule